// File: doc/BRIEF.md
# Per-Tile Supply and Clock Operating-Point Controller

This block sits in the always-on domain of one processor tile and decides at which supply rail and oscillator frequency code the tile's core runs. The core may sit on the high rail, on the low rail, or be cut off from both to save leakage. The operating point comes from one of three sources: a static configuration word, a software-written register, or a hardware policy. The hardware policy looks at how full the input FIFO is and at a smoothed stall rate. The smoothed rate is a first-order recursive average of the stall cycles counted in each fixed window.

Each rail is fed through a bank of parallel power-gate segments. To change rails, the block first halts the oscillator. It then turns off the old rail's segments one per cycle and turns on the new rail's segments one per cycle. After a settle interval it restarts the oscillator. Requests that arrive during a change wait until the change is done. A change of frequency alone on the same rail needs no halt.

Top module: `dvfs_tile_ctrl`

## Requirements
- R1: While reset is asserted, both gate vectors are zero, the oscillator enable is low, rail_o reads off (00), busy_o is low and stall_avg_o is zero. After reset the policy target is the low rail at code LO_FREQ (default 4).
- R2: src_sel_i picks the operating-point source: 00 for the hardware policy, 01 for the static cfg_rail_i/cfg_freq_i, and 10 or 11 for the software register. The software register is loaded from sw_rail_i/sw_freq_i on a cycle with sw_we_i high. Whichever source is not selected has no effect on the outputs.
- R3: Stall cycles (stall_i high) are counted over windows of WIN_LEN cycles (default 256). At the end of each window the average is updated as avg = avg + floor((count - avg) / 8), and the result is shown on stall_avg_o.
- R4: On a window update, if the average is below lo_thr_i and fifo_level_i is above three quarters of FIFO_DEPTH (default 48 of 64), the policy targets the high rail at code HI_FREQ (default 15).
- R5: On a window update where R4 does not apply, an average above hi_thr_i makes the policy target the low rail at code LO_FREQ.
- R6: When idle_i stays high for idle_timeout_i consecutive cycles (0 turns this off), the policy targets off with code 0. Window updates are then ignored until idle_i falls, and at that point the target becomes the low rail at LO_FREQ.
- R7: A rail change halts the oscillator and clears the old segments one per cycle. It then sets the new segments one per cycle up to N_SEG (default 48), waits SETTLE_CYC cycles (default 8), and restarts the oscillator. busy_o stays high for (old rail on ? N_SEG : 0) + 1 + (new rail on ? N_SEG + 1 + SETTLE_CYC : 0) cycles.
- R8: The two gate vectors are never both nonzero. The oscillator runs only when exactly one rail has all of its segments on, and it is halted whenever the rail is off.
- R9: A request that changes during a rail change is held, and it is applied by a second rail change after the first one completes.
- R10: A request with the same rail and a new frequency code reaches freq_code_o on the second clock edge after the request changes. busy_o stays low and the oscillator keeps running.
- R11: The rail code is 00 for off, 01 for low and 10 for high, and 11 is taken as high. rail_o shows the settled rail. freq_code_o reads 0 whenever the rail is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 2 | Operating-point source select |
| cfg_rail_i | input | 2 | Static rail code |
| cfg_freq_i | input | FREQ_W | Static frequency code |
| sw_we_i | input | 1 | Software register write strobe |
| sw_rail_i | input | 2 | Software rail code |
| sw_freq_i | input | FREQ_W | Software frequency code |
| stall_i | input | 1 | Core stalled this cycle |
| idle_i | input | 1 | Core idle this cycle |
| fifo_level_i | input | LVL_W | Input FIFO occupancy |
| lo_thr_i | input | AVG_W | Low stall-rate threshold |
| hi_thr_i | input | AVG_W | High stall-rate threshold |
| idle_timeout_i | input | TMO_W | Idle cycles before disconnect |
| gate_hi_o | output | N_SEG | High-rail power-gate segment enables |
| gate_lo_o | output | N_SEG | Low-rail power-gate segment enables |
| osc_run_o | output | 1 | Oscillator run enable |
| freq_code_o | output | FREQ_W | Oscillator frequency code |
| rail_o | output | 2 | Settled rail |
| busy_o | output | 1 | Rail change in progress |
| stall_avg_o | output | AVG_W | Filtered stall count |

## Verification
The bench times every rail change exactly: off to on, on to on, and on to off. A sequencer that skipped or doubled a segment step, or that left out the settle wait, would miss the expected busy length or leave a gate vector incomplete. It also changes the software request in the middle of a switch. A design that retargeted on the fly would finish on the wrong rail or produce one completion too few. Last, it drives the policy across both thresholds, through an idle timeout and a wake-up, and under a static override with a heavy stall load. A wrong filter, a wrong priority or a leaking override would produce a switch the scoreboard does not expect, or a stall_avg_o value that does not match.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    RAIL_OFF  = 2'b00,
    RAIL_LOW  = 2'b01,
    RAIL_HIGH = 2'b10,
    RAIL_ALT  = 2'b11
  } rail_e;

  typedef enum logic [1:0] {
    SQ_RUN    = 2'b00,
    SQ_DOWN   = 2'b01,
    SQ_UP     = 2'b10,
    SQ_SETTLE = 2'b11
  } seq_e;

  function automatic rail_e norm_rail(input logic [1:0] code);
    return (code == 2'b11) ? RAIL_HIGH : rail_e'(code);
  endfunction
endpackage

// File: rtl/dvfs_stall_filter.sv
module dvfs_stall_filter #(
  parameter int WIN_LEN = 256,
  parameter int SHIFT   = 3,
  localparam int WIN_W  = $clog2(WIN_LEN),
  localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  output logic [CNT_W-1:0] avg_o,
  output logic             upd_o
);
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, avg_q, sample;
  logic             upd_q;
  logic signed [CNT_W:0] diff, step, sum;

  assign sample = cnt_q + CNT_W'(stall_i);
  assign diff   = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
  assign step   = diff >>> SHIFT;
  assign sum    = $signed({1'b0, avg_q}) + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
      avg_q <= '0;
      upd_q <= 1'b0;
    end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
      win_q <= '0;
      cnt_q <= '0;
      avg_q <= sum[CNT_W-1:0];
      upd_q <= 1'b1;
    end else begin
      win_q <= win_q + 1'b1;
      cnt_q <= sample;
      upd_q <= 1'b0;
    end
  end

  assign avg_o = avg_q;
  assign upd_o = upd_q;

  AST_AVG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_q <= CNT_W'(WIN_LEN)); // R3
  AST_UPD_SPARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q); // R3
endmodule

// File: rtl/dvfs_policy.sv
module dvfs_policy
  import dvfs_pkg::*;
#(
  parameter int FREQ_W     = 4,
  parameter int AVG_W      = 9,
  parameter int LVL_W      = 7,
  parameter int TMO_W      = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int HI_FREQ    = 15,
  parameter int LO_FREQ    = 4,
  localparam int FULL_MARK = (3 * FIFO_DEPTH) / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [AVG_W-1:0]  avg_i,
  input  logic [AVG_W-1:0]  lo_thr_i,
  input  logic [AVG_W-1:0]  hi_thr_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic              idle_i,
  input  logic [TMO_W-1:0]  idle_tmo_i,
  output rail_e             rail_o,
  output logic [FREQ_W-1:0] freq_o
);
  logic [TMO_W-1:0]  idle_cnt_q;
  logic              asleep_q, fire;
  rail_e             rail_q;
  logic [FREQ_W-1:0] freq_q;

  assign fire = idle_i && !asleep_q && (idle_tmo_i != '0) &&
                (idle_cnt_q == idle_tmo_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= '0;
      asleep_q   <= 1'b0;
      rail_q     <= RAIL_LOW;
      freq_q     <= FREQ_W'(LO_FREQ);
    end else begin
      idle_cnt_q <= (idle_i && !asleep_q) ? idle_cnt_q + 1'b1 : '0;
      if (asleep_q && !idle_i) begin
        asleep_q <= 1'b0;
        rail_q   <= RAIL_LOW;
        freq_q   <= FREQ_W'(LO_FREQ);
      end else if (fire) begin
        asleep_q <= 1'b1;
        rail_q   <= RAIL_OFF;
        freq_q   <= '0;
      end else if (upd_i && !asleep_q) begin
        if (avg_i < lo_thr_i && fifo_level_i > LVL_W'(FULL_MARK)) begin
          rail_q <= RAIL_HIGH;
          freq_q <= FREQ_W'(HI_FREQ);
        end else if (avg_i > hi_thr_i) begin
          rail_q <= RAIL_LOW;
          freq_q <= FREQ_W'(LO_FREQ);
        end
      end
    end
  end

  assign rail_o = rail_q;
  assign freq_o = freq_q;

  AST_OFF_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_q == RAIL_OFF && $past(rail_q) != RAIL_OFF) |-> $past(idle_i)); // R6
endmodule

// File: rtl/dvfs_rail_seq.sv
module dvfs_rail_seq
  import dvfs_pkg::*;
#(
  parameter int N_SEG      = 48,
  parameter int SETTLE_CYC = 8,
  parameter int FREQ_W     = 4,
  localparam int SET_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rail_e             req_rail_i,
  input  logic [FREQ_W-1:0] req_freq_i,
  output logic [N_SEG-1:0]  gate_hi_o,
  output logic [N_SEG-1:0]  gate_lo_o,
  output logic              osc_run_o,
  output logic [FREQ_W-1:0] freq_o,
  output rail_e             rail_o,
  output logic              busy_o
);
  localparam logic [N_SEG-1:0] ALL_ON = {N_SEG{1'b1}};

  seq_e              st_q;
  rail_e             cur_q, tgt_q;
  logic [FREQ_W-1:0] freq_q, tgt_freq_q;
  logic [N_SEG-1:0]  hi_q, lo_q;
  logic              osc_q;
  logic [SET_W-1:0]  settle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SQ_RUN;
      cur_q      <= RAIL_OFF;
      tgt_q      <= RAIL_OFF;
      freq_q     <= '0;
      tgt_freq_q <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      osc_q      <= 1'b0;
      settle_q   <= '0;
    end else begin
      unique case (st_q)
        SQ_RUN: begin
          if (req_rail_i != cur_q) begin
            tgt_q      <= req_rail_i;
            tgt_freq_q <= (req_rail_i == RAIL_OFF) ? '0 : req_freq_i;
            osc_q      <= 1'b0;
            st_q       <= SQ_DOWN;
          end else begin
            freq_q <= (cur_q == RAIL_OFF) ? '0 : req_freq_i;
          end
        end
        SQ_DOWN: begin
          if (cur_q == RAIL_HIGH && hi_q != '0) begin
            hi_q <= hi_q >> 1;
          end else if (cur_q == RAIL_LOW && lo_q != '0) begin
            lo_q <= lo_q >> 1;
          end else if (tgt_q == RAIL_OFF) begin
            cur_q  <= RAIL_OFF;
            freq_q <= '0;
            st_q   <= SQ_RUN;
          end else begin
            st_q <= SQ_UP;
          end
        end
        SQ_UP: begin
          if (tgt_q == RAIL_HIGH && hi_q != ALL_ON) begin
            hi_q <= {hi_q[N_SEG-2:0], 1'b1};
          end else if (tgt_q == RAIL_LOW && lo_q != ALL_ON) begin
            lo_q <= {lo_q[N_SEG-2:0], 1'b1};
          end else begin
            settle_q <= '0;
            st_q     <= SQ_SETTLE;
          end
        end
        default: begin
          if (settle_q == SET_W'(SETTLE_CYC - 1)) begin
            cur_q  <= tgt_q;
            freq_q <= tgt_freq_q;
            osc_q  <= 1'b1;
            st_q   <= SQ_RUN;
          end else begin
            settle_q <= settle_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;
  assign osc_run_o = osc_q;
  assign freq_o    = freq_q;
  assign rail_o    = cur_q;
  assign busy_o    = (st_q != SQ_RUN);

  AST_RAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((hi_q != '0) && (lo_q != '0))); // R8
  AST_OSC_FULL_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_q |-> ((hi_q == ALL_ON && lo_q == '0) || (lo_q == ALL_ON && hi_q == '0))); // R8
  AST_ONE_SEG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hi_q, lo_q} ^ $past({hi_q, lo_q})) <= 1); // R7
  AST_GATES_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({hi_q, lo_q}) |-> !$past(osc_q)); // R7
  AST_TGT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SQ_RUN && $past(st_q) != SQ_RUN) |-> $stable(tgt_q)); // R9
endmodule

// File: rtl/dvfs_tile_ctrl.sv
module dvfs_tile_ctrl
  import dvfs_pkg::*;
#(
  parameter int N_SEG      = 48,
  parameter int WIN_LEN    = 256,
  parameter int SETTLE_CYC = 8,
  parameter int FREQ_W     = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int TMO_W      = 16,
  parameter int HI_FREQ    = 15,
  parameter int LO_FREQ    = 4,
  localparam int AVG_W     = $clog2(WIN_LEN + 1),
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        src_sel_i,
  input  logic [1:0]        cfg_rail_i,
  input  logic [FREQ_W-1:0] cfg_freq_i,
  input  logic              sw_we_i,
  input  logic [1:0]        sw_rail_i,
  input  logic [FREQ_W-1:0] sw_freq_i,
  input  logic              stall_i,
  input  logic              idle_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  input  logic [AVG_W-1:0]  lo_thr_i,
  input  logic [AVG_W-1:0]  hi_thr_i,
  input  logic [TMO_W-1:0]  idle_timeout_i,
  output logic [N_SEG-1:0]  gate_hi_o,
  output logic [N_SEG-1:0]  gate_lo_o,
  output logic              osc_run_o,
  output logic [FREQ_W-1:0] freq_code_o,
  output logic [1:0]        rail_o,
  output logic              busy_o,
  output logic [AVG_W-1:0]  stall_avg_o
);
  logic [1:0]        sw_rail_q;
  logic [FREQ_W-1:0] sw_freq_q;
  logic [AVG_W-1:0]  avg;
  logic              upd;
  rail_e             hw_rail, req_rail, cur_rail;
  logic [FREQ_W-1:0] hw_freq, req_freq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_rail_q <= RAIL_LOW;
      sw_freq_q <= '0;
    end else if (sw_we_i) begin
      sw_rail_q <= sw_rail_i;
      sw_freq_q <= sw_freq_i;
    end
  end

  always_comb begin
    unique case (src_sel_i)
      2'b00: begin req_rail = hw_rail;               req_freq = hw_freq;    end
      2'b01: begin req_rail = norm_rail(cfg_rail_i); req_freq = cfg_freq_i; end
      default: begin req_rail = norm_rail(sw_rail_q); req_freq = sw_freq_q; end
    endcase
  end

  dvfs_stall_filter #(.WIN_LEN(WIN_LEN), .SHIFT(3)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .avg_o(avg), .upd_o(upd)
  );

  dvfs_policy #(
    .FREQ_W(FREQ_W), .AVG_W(AVG_W), .LVL_W(LVL_W), .TMO_W(TMO_W),
    .FIFO_DEPTH(FIFO_DEPTH), .HI_FREQ(HI_FREQ), .LO_FREQ(LO_FREQ)
  ) u_policy (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .avg_i(avg),
    .lo_thr_i(lo_thr_i), .hi_thr_i(hi_thr_i), .fifo_level_i(fifo_level_i),
    .idle_i(idle_i), .idle_tmo_i(idle_timeout_i),
    .rail_o(hw_rail), .freq_o(hw_freq)
  );

  dvfs_rail_seq #(.N_SEG(N_SEG), .SETTLE_CYC(SETTLE_CYC), .FREQ_W(FREQ_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_rail_i(req_rail), .req_freq_i(req_freq),
    .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .osc_run_o(osc_run_o),
    .freq_o(freq_code_o), .rail_o(cur_rail), .busy_o(busy_o)
  );

  assign rail_o      = cur_rail;
  assign stall_avg_o = avg;

  AST_OFF_FREQ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_o == 2'b00) |-> (freq_code_o == '0 && !osc_run_o)); // R11
endmodule

// File: tb/dvfs_tile_ctrl_tb.sv
module dvfs_tile_ctrl_tb;
  localparam int NS = 48;
  localparam longint ALL = 64'hFFFF_FFFF_FFFF;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  src_sel = 0, cfg_rail = 0, sw_rail = 0;
  logic [3:0]  cfg_freq = 0, sw_freq = 0;
  logic        sw_we = 0, stall = 0, idle = 0;
  logic [6:0]  fifo_level = 60;
  logic [8:0]  lo_thr = 20, hi_thr = 100;
  logic [15:0] tmo = 50;
  logic [NS-1:0] gate_hi, gate_lo;
  logic        osc_run, busy;
  logic [3:0]  freq_code;
  logic [1:0]  rail;
  logic [8:0]  stall_avg;

  always #5 clk = ~clk;

  dvfs_tile_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel), .cfg_rail_i(cfg_rail),
    .cfg_freq_i(cfg_freq), .sw_we_i(sw_we), .sw_rail_i(sw_rail), .sw_freq_i(sw_freq),
    .stall_i(stall), .idle_i(idle), .fifo_level_i(fifo_level), .lo_thr_i(lo_thr),
    .hi_thr_i(hi_thr), .idle_timeout_i(tmo), .gate_hi_o(gate_hi), .gate_lo_o(gate_lo),
    .osc_run_o(osc_run), .freq_code_o(freq_code), .rail_o(rail), .busy_o(busy),
    .stall_avg_o(stall_avg)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard of expected rail-change completions
  int    q_rail[$], q_freq[$], q_dur[$];
  string q_tag[$];

  task automatic expect_switch(input int r, input int f, input int d, input string tag);
    q_rail.push_back(r); q_freq.push_back(f); q_dur.push_back(d); q_tag.push_back(tag);
  endtask

  int  bcnt = 0;
  bit  prev_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) bcnt++;
      else if (prev_busy) begin
        if (q_rail.size() == 0) begin
          chk(0, "R9 unexpected switch", rail, 0);
        end else begin
          int r, f, d;
          string t;
          r = q_rail.pop_front(); f = q_freq.pop_front();
          d = q_dur.pop_front();  t = q_tag.pop_front();
          chk(rail == r, {t, " rail"}, rail, r);
          chk(freq_code == f, {t, " freq"}, freq_code, f);
          chk(bcnt == d, {t, " R7 busy length"}, bcnt, d);
          chk(osc_run == (r != 0), {t, " R8 osc"}, osc_run, r != 0);
          chk(gate_hi == ((r == 2) ? NS'(ALL) : '0), {t, " R7 gate_hi"}, gate_hi, (r == 2) ? ALL : 0);
          chk(gate_lo == ((r == 1) ? NS'(ALL) : '0), {t, " R7 gate_lo"}, gate_lo, (r == 1) ? ALL : 0);
        end
        bcnt = 0;
      end
      prev_busy = busy;
    end
  end

  // independent stall-average model (R3)
  int m_win = 0, m_cnt = 0, m_avg = 0, cyc = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win <= 0; m_cnt <= 0; m_avg <= 0;
    end else if (m_win == 255) begin
      int s, dlt;
      s = m_cnt + int'(stall);
      dlt = s - m_avg;
      m_avg <= m_avg + (dlt >>> 3);
      m_win <= 0; m_cnt <= 0;
    end else begin
      m_win <= m_win + 1;
      m_cnt <= m_cnt + int'(stall);
    end
  end
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc % 256 == 128) chk(stall_avg == 9'(m_avg), "R3 stall average", stall_avg, m_avg);
    end
  end

  task automatic drain(input string tag);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (q_rail.size() == 0 && !busy) break;
    end
    chk(q_rail.size() == 0, {tag, " pending switches"}, q_rail.size(), 0);
  endtask

  task automatic sw_write(input logic [1:0] r, input logic [3:0] f);
    @(negedge clk);
    sw_rail = r; sw_freq = f; sw_we = 1;
    @(negedge clk);
    sw_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(gate_hi == '0 && gate_lo == '0, "R1 gates", {gate_hi, gate_lo}, 0);
    chk(!osc_run, "R1 osc", osc_run, 0);
    chk(rail == 2'b00 && !busy, "R1 rail/busy", {rail, busy}, 0);
    chk(stall_avg == 0, "R1 avg", stall_avg, 0);

    // R1 initial policy target low; R4 first window avg 0 with FIFO at 60 goes high
    expect_switch(1, 4, 58, "R1 wake to low");
    expect_switch(2, 15, 106, "R4 high");
    rst_n = 1;
    drain("R4");

    // R5 heavy stalling pushes the average over hi_thr
    stall = 1; fifo_level = 10;
    expect_switch(1, 4, 106, "R5 low");
    drain("R5");

    // R6 idle timeout disconnects, wake returns to low
    stall = 0; idle = 1;
    expect_switch(0, 0, 49, "R6 off");
    drain("R6 off");
    repeat (300) @(negedge clk);
    chk(rail == 2'b00, "R6 stays off while idle", rail, 0);
    idle = 0;
    expect_switch(1, 4, 58, "R6 wake");
    drain("R6 wake");

    // R2 software write ignored while hardware source selected
    sw_write(2'b10, 4'd9);
    repeat (3) @(negedge clk);
    chk(rail == 2'b01 && !busy, "R2 unselected software ignored", rail, 1);

    // R9 request changed during a switch is held and applied afterwards
    expect_switch(2, 9, 106, "R2 software high");
    expect_switch(1, 3, 106, "R9 held low");
    src_sel = 2'b10;
    while (!busy) @(negedge clk);
    repeat (5) @(negedge clk);
    sw_write(2'b01, 4'd3);
    drain("R9");

    // R10 frequency-only change on the same rail
    @(negedge clk);
    sw_rail = 2'b01; sw_freq = 4'd5; sw_we = 1;
    @(negedge clk);
    sw_we = 0;
    chk(!busy && osc_run, "R10 no halt edge1", {busy, osc_run}, 1);
    @(negedge clk);
    chk(freq_code == 4'd5, "R10 freq applied", freq_code, 5);
    chk(!busy && osc_run, "R10 no halt edge2", {busy, osc_run}, 1);

    // R11 software off forces freq code zero
    expect_switch(0, 0, 49, "R11 software off");
    sw_write(2'b00, 4'd7);
    drain("R11");

    // R2 static source, from off
    cfg_rail = 2'b10; cfg_freq = 4'd12;
    expect_switch(2, 12, 58, "R2 static high");
    src_sel = 2'b01;
    drain("R2 static");

    // R2 static overrides the policy under heavy stalling; R11 code 11 means high
    stall = 1;
    cfg_rail = 2'b11;
    repeat (1100) @(negedge clk);
    chk(rail == 2'b10, "R2 override rail", rail, 2);
    chk(freq_code == 4'd12, "R2 override freq", freq_code, 12);
    chk(!busy, "R11 code 11 held high", busy, 0);
    chk(q_rail.size() == 0, "R9 no leftover", q_rail.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule